// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt request inputs, resolves them in fixed priority, and raises one interrupt line toward the processor. When the processor answers with a run of three acknowledge strobes, the block returns a call instruction one byte at a time. The call target is a 16-bit service-routine address. Its upper bits come from software. Its lowest bits are filled in by hardware from the number of the level being serviced, so that each level lands on its own routine.

Software sets the block up through a byte-wide write port that has two addresses. The first configuration word sets three things: the top bits of the routine address's low byte, whether the request inputs are sensed by level or by rising edge, and whether routines are spaced 4 or 8 bytes apart. The second word gives the high byte of the address. After the two words the block runs in fully nested priority with no further commands. Software ends each service with a non-specific end-of-interrupt command, which releases the highest-priority level in service.

Top module: `vpic_top`

## Requirements
- R1: After reset, `intr_out` and `inta_data` are 0, and `intr_out` stays 0 whatever the inputs do until both configuration words have been written.
- R2: A write at `wr_addr`=0 with data bit 4 set is the first configuration word. It restarts configuration, clears every in-service bit and edge latch, and holds `intr_out` low from the next cycle until the second word arrives at `wr_addr`=1.
- R3: With first-word bit 3 = 0 (level sensing), an input held high raises `intr_out` two clock edges after it is applied, and keeps the request pending for as long as it is held.
- R4: With first-word bit 3 = 1 (edge sensing), only a low-to-high transition raises a request. An input that is already high gives no request. A latched request stays pending after the input falls.
- R5: Among pending requests, input 0 wins and input 7 loses. The vector always names the highest-priority pending level.
- R6: A pending request raises `intr_out` only if its level number is strictly lower than that of every level in service. A request at the same level or a lower-priority level is held back.
- R7: The first acknowledge strobe returns opcode 0xCD. The third returns the second configuration word (address bits 15..8).
- R8: With first-word bit 2 = 0 (8-byte spacing), the second strobe returns {W[7], W[6], L[2:0], 3'b000}. Here W is the first word and L is the level latched at the first strobe.
- R9: With first-word bit 2 = 1 (4-byte spacing), the second strobe returns {W[7:5], L[2:0], 2'b00}.
- R10: The second strobe marks level L in service and clears its edge latch. A serviced edge request does not fire again without a new rising edge.
- R11: Once configured, a write of 0x20 at `wr_addr`=0 clears only the lowest-numbered in-service bit. Other words with bit 4 clear are ignored.
- R12: A write at `wr_addr`=1 while not waiting for the second word changes nothing. The high vector byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 1 | 0 = lower address, 1 = upper address |
| wr_data | input | 8 | Write data |
| irq_in | input | LVL_N | Request inputs, bit 0 highest priority |
| inta | input | 1 | Acknowledge strobe, one cycle per byte |
| inta_data | output | 8 | Byte answered to the last acknowledge strobe (registered) |
| intr_out | output | 1 | Interrupt request to the processor (registered) |

## Verification
A request input is registered once, and `intr_out` is registered from that, so `intr_out` follows a change on `irq_in` two edges later. The bench applies a request and samples on the falling edge after the second rising edge. A configuration write or an end-of-interrupt write takes effect at its own edge, and `intr_out` reflects it one edge later, so those checks sit one cycle after the write. Each acknowledge byte appears right after the edge that samples its strobe. The scoreboard monitor compares it on the falling edge that follows that strobe.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD;
  localparam logic [BYTE_W-1:0] EOI_WORD    = 8'h20;

  typedef enum logic [1:0] {ACK_OP, ACK_LO, ACK_HI} ack_phase_t;
  typedef enum logic [1:0] {CFG_IDLE, CFG_WAIT_HI, CFG_RUN} cfg_state_t;

  typedef struct packed {
    logic [2:0]        base_lo;   // top bits of the low vector byte
    logic              edge_mode; // 1: rising edge requests
    logic              space4;    // 1: 4-byte spacing
    logic [BYTE_W-1:0] base_hi;   // high vector byte
  } cfg_t;
endpackage

// File: rtl/vpic_cfg.sv
module vpic_cfg
  import vpic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic              run,
  output logic              restart,
  output logic              eoi
);
  cfg_state_t state_q;
  cfg_t       cfg_q;
  logic       unused_bits;

  // bits 1..0 of the first word carry nothing this block uses
  assign unused_bits = ^wr_data[1:0];

  assign restart = wr_en && !wr_addr && wr_data[4];
  assign eoi     = wr_en && !wr_addr && (wr_data == EOI_WORD) && (state_q == CFG_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CFG_IDLE;
      cfg_q   <= '0;
    end else if (restart) begin
      state_q         <= CFG_WAIT_HI;
      cfg_q.base_lo   <= wr_data[7:5];
      cfg_q.edge_mode <= wr_data[3];
      cfg_q.space4    <= wr_data[2];
    end else if (wr_en && wr_addr && state_q == CFG_WAIT_HI) begin
      cfg_q.base_hi <= wr_data;
      state_q       <= CFG_RUN;
    end
  end

  assign cfg = cfg_q;
  assign run = (state_q == CFG_RUN);
endmodule

// File: rtl/vpic_req.sv
module vpic_req #(
  parameter int LVL_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_all,
  input  logic             edge_mode,
  input  logic [LVL_N-1:0] irq_in,
  input  logic [LVL_N-1:0] ack_clr,
  output logic [LVL_N-1:0] req
);
  logic [LVL_N-1:0] irq_q;
  logic [LVL_N-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_in;
  end

  for (genvar g = 0; g < LVL_N; g++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst || clear_all)           lat_q[g] <= 1'b0;
      else if (irq_in[g] && !irq_q[g]) lat_q[g] <= 1'b1;
      else if (ack_clr[g])             lat_q[g] <= 1'b0;
    end
  end

  assign req = edge_mode ? lat_q : irq_q;
endmodule

// File: rtl/vpic_prio.sv
module vpic_prio #(
  parameter int LVL_N = 8,
  localparam int LVL_W = $clog2(LVL_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_all,
  input  logic [LVL_N-1:0] req,
  input  logic             set_en,
  input  logic [LVL_W-1:0] set_lvl,
  input  logic             eoi,
  output logic [LVL_N-1:0] isr,
  output logic [LVL_W-1:0] win_lvl,
  output logic             pass
);
  logic [LVL_N-1:0] isr_q, isr_nxt;
  logic [LVL_W-1:0] isr_top;

  function automatic logic [LVL_W-1:0] first_set(input logic [LVL_N-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = LVL_N - 1; i >= 0; i--)
      if (v[i]) r = LVL_W'(i);
    return r;
  endfunction

  assign win_lvl = first_set(req);
  assign isr_top = first_set(isr_q);
  assign pass    = (|req) && (!(|isr_q) || (win_lvl < isr_top));

  always_comb begin
    isr_nxt = isr_q;
    if (eoi && (|isr_q)) isr_nxt[isr_top] = 1'b0;
    if (set_en)          isr_nxt[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_all) isr_q <= '0;
    else                  isr_q <= isr_nxt;
  end

  assign isr = isr_q;
endmodule

// File: rtl/vpic_ack.sv
module vpic_ack
  import vpic_pkg::*;
#(
  parameter int LVL_N = 8,
  localparam int LVL_W = $clog2(LVL_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_all,
  input  logic              run,
  input  logic              inta,
  input  cfg_t              cfg,
  input  logic [LVL_W-1:0]  win_lvl,
  output logic [BYTE_W-1:0] inta_data,
  output logic              set_en,
  output logic [LVL_W-1:0]  set_lvl
);
  ack_phase_t        phase_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] lo_byte;
  logic              step;

  // vector layout assumes eight levels (three level bits)
  always_comb begin
    if (cfg.space4) lo_byte = {cfg.base_lo, lvl_q, 2'b00};
    else            lo_byte = {cfg.base_lo[2:1], lvl_q, 3'b000};
  end

  assign step    = inta && run && !clear_all;
  assign set_en  = step && (phase_q == ACK_LO);
  assign set_lvl = lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= ACK_OP;
      lvl_q   <= '0;
      data_q  <= '0;
    end else if (clear_all) begin
      phase_q <= ACK_OP;
    end else if (step) begin
      unique case (phase_q)
        ACK_OP: begin
          data_q  <= CALL_OPCODE;
          lvl_q   <= win_lvl;
          phase_q <= ACK_LO;
        end
        ACK_LO: begin
          data_q  <= lo_byte;
          phase_q <= ACK_HI;
        end
        default: begin
          data_q  <= cfg.base_hi;
          phase_q <= ACK_OP;
        end
      endcase
    end
  end

  assign inta_data = data_q;
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int LVL_N = 8,
  localparam int LVL_W = $clog2(LVL_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [LVL_N-1:0]  irq_in,
  input  logic              inta,
  output logic [BYTE_W-1:0] inta_data,
  output logic              intr_out
);
  cfg_t             cfg_q;
  logic             run, restart, eoi;
  logic [LVL_N-1:0] req, isr, ack_clr;
  logic [LVL_W-1:0] win_lvl, set_lvl;
  logic             pass, set_en;
  logic             intr_q;

  vpic_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg_q), .run(run), .restart(restart), .eoi(eoi)
  );

  vpic_req #(.LVL_N(LVL_N)) u_req (
    .clk(clk), .rst(rst), .clear_all(restart), .edge_mode(cfg_q.edge_mode),
    .irq_in(irq_in), .ack_clr(ack_clr), .req(req)
  );

  vpic_prio #(.LVL_N(LVL_N)) u_prio (
    .clk(clk), .rst(rst), .clear_all(restart), .req(req), .set_en(set_en),
    .set_lvl(set_lvl), .eoi(eoi), .isr(isr), .win_lvl(win_lvl), .pass(pass)
  );

  vpic_ack #(.LVL_N(LVL_N)) u_ack (
    .clk(clk), .rst(rst), .clear_all(restart), .run(run), .inta(inta),
    .cfg(cfg_q), .win_lvl(win_lvl), .inta_data(inta_data),
    .set_en(set_en), .set_lvl(set_lvl)
  );

  always_comb begin
    ack_clr = '0;
    if (set_en) ack_clr[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) intr_q <= 1'b0;
    else     intr_q <= run && pass && !restart;
  end

  assign intr_out = intr_q;
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
  parameter int LVL_N = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [7:0]       wr_data,
  input logic             inta,
  input logic [7:0]       inta_data,
  input logic             intr_out,
  input logic             run,
  input logic [7:0]       base_hi,
  input logic [LVL_N-1:0] isr
);
  logic       first_wr;
  logic [1:0] ph;

  assign first_wr = wr_en && !wr_addr && wr_data[4];

  // independent count of acknowledge strobes
  always_ff @(posedge clk) begin
    if (rst || first_wr)  ph <= 2'd0;
    else if (inta && run) ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
  end

  // R2
  init_hold_chk: assert property (@(posedge clk) disable iff (rst)
    first_wr |=> !intr_out);

  // R7
  opcode_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (inta && run && !first_wr && ph == 2'd0) |=> (inta_data == 8'hCD));

  // R7
  high_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (inta && run && !first_wr && ph == 2'd2) |=> (inta_data == $past(base_hi)));

  // R10
  in_service_set_chk: assert property (@(posedge clk) disable iff (rst)
    (inta && run && !first_wr && ph == 2'd1) |=> (isr != '0));

  // R11
  eoi_single_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr && wr_data == 8'h20 && run && (|isr) && !inta)
      |=> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

bind vpic_top vpic_chk #(.LVL_N(LVL_N)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .inta(inta), .inta_data(inta_data), .intr_out(intr_out), .run(run),
  .base_hi(cfg_q.base_hi), .isr(isr)
);

// File: tb/test_vpic_top.sv
`timescale 1ns/1ps
module test_vpic_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] irq = '0;
  logic       inta = 1'b0;
  logic [7:0] inta_data;
  logic       intr_out;
  logic       ack_q = 1'b0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  vpic_top i_vpic_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_in(irq), .inta(inta), .inta_data(inta_data), .intr_out(intr_out)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] lo_byte(input logic [7:0] w1, input logic [2:0] lvl);
    if (w1[2]) return {w1[7:5], lvl, 2'b00};
    return {w1[7:6], lvl, 3'b000};
  endfunction

  // driver: pushes the expected bytes, then issues the strobes
  task automatic ack(input logic [7:0] lo, input logic [7:0] hi, input string tag);
    logic [7:0] e[3];
    e[0] = 8'hCD; e[1] = lo; e[2] = hi;
    for (int i = 0; i < 3; i++) begin
      q_exp.push_back(e[i]);
      q_tag.push_back($sformatf("%s byte%0d", tag, i));
      inta = 1'b1;
      @(negedge clk);
      inta = 1'b0;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) ack_q <= inta;

  // monitor: the byte is due right after the edge that sampled the strobe
  always @(negedge clk) begin
    if (ack_q) begin
      if (q_exp.size() == 0) chk(inta_data, 8'hxx, "scoreboard empty");
      else chk(inta_data, q_exp.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk({7'd0, intr_out}, 8'd0, "R1 reset intr");
    chk(inta_data, 8'd0, "R1 reset data");
    irq[3] = 1'b1;
    step(3);
    chk({7'd0, intr_out}, 8'd0, "R1 unconfigured");

    // level sensing, 8-byte spacing: W1 = 0xB2, W2 = 0x3C
    wr(1'b0, 8'hB2);
    step(1);
    chk({7'd0, intr_out}, 8'd0, "R2 waiting for second word");
    wr(1'b1, 8'h3C);
    step(1);
    chk({7'd0, intr_out}, 8'd1, "R3 level request");
    ack(lo_byte(8'hB2, 3'd3), 8'h3C, "R8 level3");
    chk({7'd0, intr_out}, 8'd0, "R6 same level in service");
    irq[5] = 1'b1;
    step(2);
    chk({7'd0, intr_out}, 8'd0, "R6 lower priority held");
    irq[1] = 1'b1;
    step(2);
    chk({7'd0, intr_out}, 8'd1, "R6 higher priority nests");
    ack(lo_byte(8'hB2, 3'd1), 8'h3C, "R5 level1 over level5");
    chk({7'd0, intr_out}, 8'd0, "R10 in service after ack");
    irq[1] = 1'b0; irq[3] = 1'b0;
    wr(1'b0, 8'h60);
    wr(1'b0, 8'h20);
    step(1);
    chk({7'd0, intr_out}, 8'd0, "R11 one bit cleared, other word ignored");
    wr(1'b0, 8'h20);
    step(1);
    chk({7'd0, intr_out}, 8'd1, "R11 second clear");
    wr(1'b1, 8'h55);
    step(1);
    chk({7'd0, intr_out}, 8'd1, "R12 upper write no restart");
    ack(lo_byte(8'hB2, 3'd5), 8'h3C, "R12 high byte kept");
    irq[5] = 1'b0;
    wr(1'b0, 8'h20);

    // edge sensing, 4-byte spacing: W1 = 0x7E, W2 = 0xA5; irq[2] held high
    irq[2] = 1'b1;
    step(2);
    wr(1'b0, 8'h7E);
    step(1);
    chk({7'd0, intr_out}, 8'd0, "R2 restart holds intr");
    wr(1'b1, 8'hA5);
    step(2);
    chk({7'd0, intr_out}, 8'd0, "R4 held input no edge");
    irq[2] = 1'b0;
    irq[6] = 1'b1;
    step(1);
    irq[6] = 1'b0;
    step(1);
    chk({7'd0, intr_out}, 8'd1, "R4 edge latched after fall");
    ack(lo_byte(8'h7E, 3'd6), 8'hA5, "R9 level6");
    chk({7'd0, intr_out}, 8'd0, "R10 latch cleared");
    wr(1'b0, 8'h20);
    step(2);
    chk({7'd0, intr_out}, 8'd0, "R10 no refire after clear");
    irq[7] = 1'b1; irq[4] = 1'b1;
    step(2);
    chk({7'd0, intr_out}, 8'd1, "R4 two edges");
    ack(lo_byte(8'h7E, 3'd4), 8'hA5, "R5 level4 over level7");
    chk({7'd0, intr_out}, 8'd0, "R6 level7 held by level4");
    wr(1'b0, 8'h20);
    step(1);
    chk({7'd0, intr_out}, 8'd1, "R11 level7 released");
    ack(lo_byte(8'h7E, 3'd7), 8'hA5, "R9 level7");
    irq[7] = 1'b0; irq[4] = 1'b0;
    step(1);
    wr(1'b0, 8'h7E);
    step(1);
    chk({7'd0, intr_out}, 8'd0, "R2 restart again");
    wr(1'b1, 8'hA5);
    irq[7] = 1'b1;
    step(2);
    chk({7'd0, intr_out}, 8'd1, "R2 in-service cleared by restart");
    step(2);
    chk(8'(q_exp.size()), 8'd0, "R7 scoreboard drained");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule